// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This block lets the cores of a small cluster, up to four by default, interrupt one another from software. Each core owns a command port. A command has an operation code and a core-index argument, and it is held with a valid bit until the unit raises that core's ready. Four operations are available:

- ask whether another core has an interrupt pending;
- raise an interrupt at another core;
- ask which cores are behind the interrupt pending at the issuing core;
- acknowledge one of those senders.

The answer to a query comes back on the core's readback word.

For every receiving core the unit keeps a sender bitmask. Two or more cores that raise the same target therefore merge into a single asserted interrupt line, and the target sees several bits in its sender mask. The line stays up until every sender bit has been acknowledged. Each acknowledge clears exactly one bit. Commands that arrive in the same cycle are served one per cycle, in fixed priority order.

Top module: `icx_signal_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every interrupt output is low, every readback word is zero and every sender mask is empty.
- R2: Operation code 0 (pending query) with argument t returns in the readback word bit 0 = 1 if core t has at least one sender bit set, with all other bits zero.
- R3: Operation code 1 (raise) from core s with argument t, where t differs from s, sets bit s of core t's sender mask. irq[t] is high in the cycle after the command is accepted.
- R4: A raise whose argument equals the issuing core is ignored. No mask bit and no interrupt output changes.
- R5: Operation code 2 (sender query) returns the issuing core's sender mask in the low readback bits, with bit i standing for core i. A single sender i gives the value 2^i.
- R6: Raises from several cores to one target merge into one asserted interrupt line, and the target's sender mask then has one bit per sender.
- R7: Operation code 3 (acknowledge) from core r with argument s clears only bit s of core r's sender mask. The other bits are left unchanged.
- R8: irq[t] stays high while any bit of core t's sender mask is set, and goes low in the cycle after the last bit is cleared.
- R9: At most one command is accepted per cycle. Among the cores whose valid is high, only the lowest-indexed one sees ready; the others wait.
- R10: The readback word changes only in the cycle after a command from that core is accepted, and then holds its value. Raise and acknowledge commands return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | N_CORES | Per-core command request |
| cmd_op | input | 2*N_CORES | Per-core operation code, core c in bits [2c+1:2c] |
| cmd_arg | input | IDX_W*N_CORES | Per-core core-index argument |
| cmd_ready | output | N_CORES | Per-core accept; a command is taken when valid and ready are both high |
| rdata | output | DATA_W*N_CORES | Per-core readback word |
| irq | output | N_CORES | Per-core inter-core interrupt line |

## Verification
The assertions check the arbiter's behaviour on every cycle: one grant at a time, no grant without a request, and core 0 always winning. They also check, each cycle, that an interrupt line rises only after an accepted raise and falls only after an accepted acknowledge, that a self-raise never brings a quiet line up, and that a readback word stays still unless its core had a command accepted. Only the bench scenarios can show the actual values. These are the merged multi-bit sender mask, the one-bit-at-a-time clearing by acknowledge, the answers to pending queries, and the order in which contending cores are served. The bench compares each of these against its reference model.

// File: rtl/icx_pkg.sv
package icx_pkg;
  typedef enum logic [1:0] {
    OP_PEEK  = 2'd0,
    OP_RAISE = 2'd1,
    OP_WHO   = 2'd2,
    OP_ACK   = 2'd3
  } icx_op_e;
endpackage

// File: rtl/icx_prio_arb.sv
module icx_prio_arb #(
  parameter int N_CORES = 4
) (
  input  logic [N_CORES-1:0] req,
  output logic [N_CORES-1:0] gnt
);
  // Lowest requesting index wins; descending scan lets it overwrite.
  always_comb begin
    gnt = '0;
    for (int i = N_CORES - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/icx_src_bank.sv
module icx_src_bank
  import icx_pkg::*;
#(
  parameter int N_CORES = 4,
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc,
  input  logic [IDX_W-1:0]       sel_core,
  input  icx_op_e                sel_op,
  input  logic [IDX_W-1:0]       sel_arg,
  output logic [N_CORES*N_CORES-1:0] mask_flat,
  output logic [N_CORES-1:0]     irq
);
  // Row t holds the senders pending at core t; bit s is sender s.
  logic [N_CORES-1:0] mask_q [N_CORES];
  logic [N_CORES-1:0] mask_d [N_CORES];
  logic [N_CORES-1:0] irq_q;

  function automatic logic in_range(input logic [IDX_W-1:0] x);
    return 32'(x) < N_CORES;
  endfunction

  always_comb begin
    for (int t = 0; t < N_CORES; t++) mask_d[t] = mask_q[t];
    if (acc) begin
      unique case (sel_op)
        OP_RAISE: if (in_range(sel_arg) && (sel_arg != sel_core))
                    mask_d[sel_arg][sel_core] = 1'b1;
        OP_ACK:   if (in_range(sel_arg))
                    mask_d[sel_core][sel_arg] = 1'b0;
        default: ;
      endcase
    end
  end

  for (genvar t = 0; t < N_CORES; t++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[t] <= '0;
        irq_q[t]  <= 1'b0;
      end else begin
        mask_q[t] <= mask_d[t];
        irq_q[t]  <= |mask_d[t];
      end
    end
    assign mask_flat[t*N_CORES +: N_CORES] = mask_q[t];
  end

  assign irq = irq_q;
endmodule

// File: rtl/icx_readback.sv
module icx_readback
  import icx_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc,
  input  logic [IDX_W-1:0]           sel_core,
  input  icx_op_e                    sel_op,
  input  logic [IDX_W-1:0]           sel_arg,
  input  logic [N_CORES*N_CORES-1:0] mask_flat,
  output logic [N_CORES*DATA_W-1:0]  rdata
);
  logic [N_CORES-1:0] row [N_CORES];
  logic [DATA_W-1:0]  rd_val;

  for (genvar t = 0; t < N_CORES; t++) begin : g_unpack
    assign row[t] = mask_flat[t*N_CORES +: N_CORES];
  end

  always_comb begin
    rd_val = '0;
    unique case (sel_op)
      OP_PEEK: if (32'(sel_arg) < N_CORES) rd_val[0] = |row[sel_arg];
      OP_WHO:  rd_val = DATA_W'(row[sel_core]);
      default: rd_val = '0;
    endcase
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_word
    logic [DATA_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (rst)
        rd_q <= '0;
      else if (acc && (sel_core == IDX_W'(c)))
        rd_q <= rd_val;
    end
    assign rdata[c*DATA_W +: DATA_W] = rd_q;
  end
endmodule

// File: rtl/icx_signal_unit.sv
module icx_signal_unit
  import icx_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CORES-1:0]        cmd_valid,
  input  logic [2*N_CORES-1:0]      cmd_op,
  input  logic [IDX_W*N_CORES-1:0]  cmd_arg,
  output logic [N_CORES-1:0]        cmd_ready,
  output logic [DATA_W*N_CORES-1:0] rdata,
  output logic [N_CORES-1:0]        irq
);
  logic [N_CORES-1:0]         gnt;
  logic                       acc;
  logic [IDX_W-1:0]           sel_core;
  logic [IDX_W-1:0]           sel_arg;
  icx_op_e                    sel_op;
  logic [N_CORES*N_CORES-1:0] mask_flat;

  icx_prio_arb #(.N_CORES(N_CORES)) u_arb (
    .req (cmd_valid),
    .gnt (gnt)
  );

  assign cmd_ready = gnt;

  // Route the single granted command to the shared state.
  always_comb begin
    acc      = |gnt;
    sel_core = '0;
    sel_op   = OP_PEEK;
    sel_arg  = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (gnt[i]) begin
        sel_core = IDX_W'(i);
        sel_op   = icx_op_e'(cmd_op[2*i +: 2]);
        sel_arg  = cmd_arg[i*IDX_W +: IDX_W];
      end
    end
  end

  icx_src_bank #(.N_CORES(N_CORES)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .sel_core  (sel_core),
    .sel_op    (sel_op),
    .sel_arg   (sel_arg),
    .mask_flat (mask_flat),
    .irq       (irq)
  );

  icx_readback #(.N_CORES(N_CORES), .DATA_W(DATA_W)) u_rb (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .sel_core  (sel_core),
    .sel_op    (sel_op),
    .sel_arg   (sel_arg),
    .mask_flat (mask_flat),
    .rdata     (rdata)
  );
endmodule

// File: rtl/icx_signal_unit_chk.sv
module icx_signal_unit_chk #(
  parameter int N_CORES = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_CORES-1:0]        cmd_valid,
  input logic [2*N_CORES-1:0]      cmd_op,
  input logic [IDX_W*N_CORES-1:0]  cmd_arg,
  input logic [N_CORES-1:0]        cmd_ready,
  input logic [DATA_W*N_CORES-1:0] rdata,
  input logic [N_CORES-1:0]        irq
);
  logic [N_CORES-1:0] acc_v;
  logic               raise_any;
  logic               ack_any;

  assign acc_v = cmd_valid & cmd_ready;

  always_comb begin
    raise_any = 1'b0;
    ack_any   = 1'b0;
    for (int i = 0; i < N_CORES; i++) begin
      if (acc_v[i] && cmd_op[2*i +: 2] == 2'd1) raise_any = 1'b1;
      if (acc_v[i] && cmd_op[2*i +: 2] == 2'd3) ack_any   = 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (irq == '0));

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_ready));

  assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready & ~cmd_valid) == '0);

  assert_core0_wins_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid[0] |-> cmd_ready[0]);

  for (genvar t = 0; t < N_CORES; t++) begin : g_core
    logic [IDX_W-1:0] arg_t;
    logic [1:0]       op_t;
    assign arg_t = cmd_arg[t*IDX_W +: IDX_W];
    assign op_t  = cmd_op[2*t +: 2];

    assert_irq_rise_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[t]) |-> $past(raise_any));

    assert_irq_fall_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(irq[t]) |-> $past(ack_any));

    assert_self_ignored_R4: assert property (@(posedge clk) disable iff (rst)
      (acc_v[t] && op_t == 2'd1 && arg_t == IDX_W'(t) && !irq[t]) |=> !irq[t]);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !acc_v[t] |=> $stable(rdata[t*DATA_W +: DATA_W]));
  end
endmodule

bind icx_signal_unit icx_signal_unit_chk #(.N_CORES(N_CORES), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_arg   (cmd_arg),
  .cmd_ready (cmd_ready),
  .rdata     (rdata),
  .irq       (irq)
);

// File: tb/tb_icx_signal_unit.sv
`timescale 1ns/1ps
module tb_icx_signal_unit;
  localparam int N = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  v = '0;
  logic [1:0]    o [N];
  logic [1:0]    a [N];
  logic [N-1:0]  cmd_ready;
  logic [N*DW-1:0] rdata;
  logic [N-1:0]  irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int acc_cyc [N];
  bit finished = 0;

  // Reference state
  bit [N-1:0] mmask [N];
  int         erd [N];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  icx_signal_unit #(.N_CORES(N), .DATA_W(DW)) dut (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (v),
    .cmd_op    ({o[3], o[2], o[1], o[0]}),
    .cmd_arg   ({a[3], a[2], a[1], a[0]}),
    .cmd_ready (cmd_ready),
    .rdata     (rdata),
    .irq       (irq)
  );

  function automatic int rd(int c);
    return int'(rdata[c*DW +: DW]);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on every clock edge.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin mmask[i] = '0; erd[i] = 0; end
    end else begin
      int w;
      w = -1;
      for (int i = N - 1; i >= 0; i--) if (v[i]) w = i;
      if (w >= 0) begin
        case (o[w])
          2'd0: erd[w] = (mmask[a[w]] != 0) ? 1 : 0;
          2'd2: erd[w] = int'(mmask[w]);
          2'd1: begin erd[w] = 0; if (int'(a[w]) != w) mmask[a[w]][w] = 1'b1; end
          default: begin erd[w] = 0; mmask[w][a[w]] = 1'b0; end
        endcase
      end
    end
  end

  // Every-cycle comparison, away from the clock edge.
  always @(negedge clk) begin
    #1;
    if (!rst && !finished) begin
      int exp_rdy;
      exp_rdy = 0;
      for (int i = N - 1; i >= 0; i--) if (v[i]) exp_rdy = 1 << i;
      chk("R9 ready", int'(cmd_ready), exp_rdy);
      for (int t = 0; t < N; t++) begin
        chk("R8 irq", int'(irq[t]), (mmask[t] != 0) ? 1 : 0);
        chk("R10 rdata", rd(t), erd[t]);
      end
    end
  end

  task automatic send(int c, int op, int arg);
    bit ok;
    @(negedge clk);
    v[c] = 1'b1; o[c] = op[1:0]; a[c] = arg[1:0];
    do begin
      #0.5;
      ok = cmd_ready[c];
      if (!ok) @(negedge clk);
    end while (!ok);
    acc_cyc[c] = cyc;
    @(negedge clk);
    v[c] = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin o[i] = 2'd0; a[i] = 2'd0; end
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 rdata in reset", int'(rdata), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", int'(irq), 0);

    send(0, 0, 2);
    chk("R2 peek idle", rd(0), 0);

    send(1, 1, 2);
    chk("R3 irq raised", int'(irq), 4'b0100);
    chk("R10 raise returns zero", rd(1), 0);

    send(0, 0, 2);
    chk("R2 peek pending", rd(0), 1);
    repeat (3) @(negedge clk);
    chk("R10 readback held", rd(0), 1);

    send(3, 1, 3);
    chk("R4 self raise no irq", int'(irq[3]), 0);
    send(3, 2, 0);
    chk("R4 self raise no mask", rd(3), 0);

    fork
      send(3, 1, 2);
      send(0, 1, 2);
    join
    chk("R9 core0 before core3", (acc_cyc[0] < acc_cyc[3]) ? 1 : 0, 1);
    chk("R6 single line", int'(irq), 4'b0100);
    send(2, 2, 0);
    chk("R6 merged mask", rd(2), 8'h0B);

    send(2, 3, 1);
    chk("R8 irq held", int'(irq[2]), 1);
    send(2, 2, 0);
    chk("R7 one bit cleared", rd(2), 8'h09);
    send(2, 3, 0);
    chk("R8 irq still held", int'(irq[2]), 1);
    send(2, 3, 3);
    chk("R8 irq drops", int'(irq[2]), 0);
    send(2, 2, 0);
    chk("R7 mask empty", rd(2), 0);

    send(3, 1, 0);
    send(0, 2, 0);
    chk("R5 sender 3", rd(0), 8'h08);
    send(1, 1, 3);
    send(3, 2, 0);
    chk("R5 sender 1", rd(3), 8'h02);

    fork
      send(3, 0, 0);
      send(2, 0, 0);
      send(1, 0, 0);
    join
    chk("R9 core1 before core2", (acc_cyc[1] < acc_cyc[2]) ? 1 : 0, 1);
    chk("R9 core2 before core3", (acc_cyc[2] < acc_cyc[3]) ? 1 : 0, 1);
    chk("R2 peek from three", rd(1) + rd(2) + rd(3), 3);

    send(0, 3, 3);
    chk("R8 core0 irq drops", int'(irq[0]), 0);
    send(3, 3, 1);
    chk("R8 core3 irq drops", int'(irq[3]), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule